// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block keeps one 32-bit window register per flash chip select and uses the registers to route system addresses to flash devices. Each register places its chip select in the system address space as a start and an end, both counted in 8 MB units. Software writes the registers through a simple register port. The block cleans each write against fixed rules before it takes effect. A rejected write leaves the register unchanged. Other rule violations are accepted and raise a sticky error flag.

Two lookup paths use the stored windows. The system decode path takes a system address and returns a one-hot chip-select hit together with the byte offset inside that window. The flash access path takes a chip-select index and a flash-relative offset, and folds the offset back into that chip select's segment size. Both paths give a result one clock after the request. The error flags stay set until software clears them through a write-one-to-clear status register.

Top module: `seg_window_dec`

## Requirements
- R1: Register index i (below NUM_CS) holds window i, with end in bits [31:24] and start in bits [23:16], each in 8 MB units. Bits [15:0] always read zero. A window's size is end minus start when end is greater than start, and zero otherwise. Index NUM_CS is the status register, with bit 0 = overlap, bit 1 = misaligned start, bit 2 = out-of-window write rejected, bit 3 = flash offset wrapped. Any other index reads zero.
- R2: After reset, window 0 starts at BASE_U and spans CS0_U units. Each following window spans CSN_U units and starts where the previous one ends. The status register reads zero.
- R3: A write to window 0 always stores BASE_U as its start, whatever start it carries. The end field is stored as written.
- R4: A write whose end is at or below BASE_U, or whose (corrected) start is above BASE_U+WIN_U, is discarded: the register keeps its old value and status bit 2 is set. A start exactly equal to BASE_U+WIN_U is accepted.
- R5: An accepted write with a non-zero size whose start is not a multiple of its size is stored and sets status bit 1. This also holds when the size is not a power of two.
- R6: An accepted write whose window overlaps the current window of any other chip select is stored and sets status bit 0. Two windows overlap when both sizes are non-zero and each start is below the other's end. Windows that only touch do not overlap, and an empty window overlaps nothing.
- R7: A write whose 32-bit data equals the register's current contents changes nothing and sets no flag.
- R8: A system decode request gives, one cycle later, dec_vld high and a one-hot dec_sel. The selected chip select is the lowest-index window with start <= address[ADDR_W-1:23] < end, and dec_off is the address minus the start times 8 MB. On a miss, dec_sel and dec_off are zero.
- R9: A flash access request gives, one cycle later, acc_vld high and the offset reduced modulo the chosen window's size (size times 8 MB). If the offset was at or above the size, status bit 3 is set. A zero size gives offset zero and sets bit 3.
- R10: Status bits are sticky. Writing to the status index clears the bits written as one and leaves the others. When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dec_req | input | 1 | System decode request |
| dec_addr | input | ADDR_W | System address to decode |
| dec_vld | output | 1 | Decode result valid |
| dec_sel | output | NUM_CS | One-hot chip-select hit |
| dec_off | output | ADDR_W | Byte offset inside the hit window |
| acc_req | input | 1 | Flash access request |
| acc_cs | input | CSW | Chip select of the access |
| acc_off | input | ADDR_W | Flash-relative offset to fold |
| acc_vld | output | 1 | Folded offset valid |
| acc_off_q | output | ADDR_W | Offset folded into the window size |

## Verification
The assertions assume that reset is held for at least one clock edge, and that reg_addr, acc_cs and dec_addr are stable around the edge at which their request is sampled. The bench drives every input on the falling edge and holds it for a full cycle, so each request is seen cleanly by exactly one rising edge. The offset-range property assumes the chosen window is not rewritten in the cycle of the access. The stimulus never issues a window write and an access in the same cycle. The only concurrent activity it creates is a status clear together with a flag set.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int UNIT_W = 8;
   localparam int ST_OVL = 0;
   localparam int ST_MIS = 1;
   localparam int ST_REJ = 2;
   localparam int ST_WRAP = 3;
   localparam int ST_W = 4;

   // window length in units; inverted or equal bounds mean empty
   function automatic logic [UNIT_W-1:0] seg_len(input logic [UNIT_W-1:0] e,
                                                 input logic [UNIT_W-1:0] s);
      return (e > s) ? (e - s) : '0;
   endfunction

   function automatic logic is_pow2(input logic [UNIT_W-1:0] v);
      return (v != '0) && ((v & (v - 1'b1)) == '0);
   endfunction
endpackage

// File: rtl/seg_umod.sv
// Unrolled restoring remainder: one compare-subtract stage per numerator bit.
module seg_umod #(
   parameter int NW = 9,
   parameter int DW = 8
) (
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [DW-1:0] rem
);
   logic [DW-1:0] r [NW+1];
   assign r[0] = '0;

   for (genvar g = 0; g < NW; g++) begin : g_stage
      logic [DW:0] t;
      assign t = {r[g], num[NW-1-g]};
      assign r[g+1] = (t >= {1'b0, den}) ? DW'(t - {1'b0, den}) : DW'(t);
   end

   assign rem = (den == '0) ? '0 : r[NW];
endmodule

// File: rtl/seg_off_wrap.sv
module seg_off_wrap
   import seg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int UNIT_SH = 23,
   parameter bit NPOT    = 1'b1
) (
   input  logic [ADDR_W-1:0] off,
   input  logic [UNIT_W-1:0] size_u,
   output logic [ADDR_W-1:0] off_o,
   output logic              over
);
   localparam int HW = ADDR_W - UNIT_SH;

   logic [HW-1:0] hi, hi_mask, hi_new;
   logic          p2;

   assign hi      = off[ADDR_W-1:UNIT_SH];
   assign p2      = is_pow2(size_u);
   assign hi_mask = hi & HW'(size_u - 1'b1);
   assign over    = (HW'(size_u) <= hi);

   if (NPOT) begin : g_npot
      logic [UNIT_W-1:0] rem;
      seg_umod #(.NW(HW), .DW(UNIT_W)) u_mod (.num(hi), .den(size_u), .rem(rem));
      assign hi_new = p2 ? hi_mask : HW'(rem);
   end else begin : g_mask
      assign hi_new = hi_mask;
   end

   assign off_o = (size_u == '0) ? '0 : {hi_new, off[UNIT_SH-1:0]};
endmodule

// File: rtl/seg_wr_check.sv
module seg_wr_check
   import seg_pkg::*;
#(
   parameter int NUM_CS = 5,
   parameter int BASE_U = 'h40,
   parameter int WIN_U  = 32,
   parameter bit NPOT   = 1'b1,
   localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic [CSW-1:0]         cs,
   input  logic [15:0]            wfield,
   input  logic [NUM_CS*16-1:0]   seg_hi,
   output logic [15:0]            store_hi,
   output logic                   reject,
   output logic                   misalign,
   output logic                   overlap
);
   localparam logic [9:0] BASE10  = 10'(BASE_U);
   localparam logic [9:0] LIMIT10 = 10'(BASE_U + WIN_U);

   logic [UNIT_W-1:0] ne, ns, len, rem;
   logic [NUM_CS-1:0] hit;

   assign ne       = wfield[15:8];
   assign ns       = (cs == '0) ? UNIT_W'(BASE_U) : wfield[7:0];
   assign store_hi = {ne, ns};
   assign len      = seg_len(ne, ns);
   assign reject   = ({2'b0, ne} <= BASE10) || ({2'b0, ns} > LIMIT10);

   if (NPOT) begin : g_npot
      seg_umod #(.NW(UNIT_W), .DW(UNIT_W)) u_mod (.num(ns), .den(len), .rem(rem));
   end else begin : g_mask
      assign rem = ns & (len - 1'b1);
   end
   assign misalign = (len != '0) && (rem != '0);

   for (genvar j = 0; j < NUM_CS; j++) begin : g_ovl
      logic [UNIT_W-1:0] oe, os;
      assign oe = seg_hi[j*16+8 +: 8];
      assign os = seg_hi[j*16 +: 8];
      assign hit[j] = (cs != CSW'(j)) && (len != '0) && (seg_len(oe, os) != '0)
                      && (ns < oe) && (os < ne);
   end
   assign overlap = |hit;
endmodule

// File: rtl/seg_addr_dec.sv
module seg_addr_dec
   import seg_pkg::*;
#(
   parameter int NUM_CS  = 5,
   parameter int ADDR_W  = 32,
   parameter int UNIT_SH = 23
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_CS*16-1:0] seg_hi,
   output logic [NUM_CS-1:0]    sel,
   output logic [ADDR_W-1:0]    off
);
   localparam int HW = ADDR_W - UNIT_SH;

   logic [HW-1:0]     au;
   logic [NUM_CS-1:0] hit;
   logic [ADDR_W-1:0] offs [NUM_CS];

   assign au = addr[ADDR_W-1:UNIT_SH];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_win
      logic [UNIT_W-1:0] e, s;
      assign e = seg_hi[i*16+8 +: 8];
      assign s = seg_hi[i*16 +: 8];
      assign hit[i]  = (HW'(s) <= au) && (au < HW'(e));
      assign offs[i] = addr - (ADDR_W'(s) << UNIT_SH);
   end

   // lowest index wins when windows overlap
   always_comb begin
      logic found;
      found = 1'b0;
      sel   = '0;
      off   = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit[i] && !found) begin
            sel[i] = 1'b1;
            off    = offs[i];
            found  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/seg_window_dec.sv
module seg_window_dec
   import seg_pkg::*;
#(
   parameter int NUM_CS  = 5,
   parameter int ADDR_W  = 32,
   parameter int UNIT_SH = 23,
   parameter int BASE_U  = 'h40,
   parameter int WIN_U   = 32,
   parameter int CS0_U   = 8,
   parameter int CSN_U   = 4,
   parameter bit NPOT    = 1'b1,
   localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int RAW    = $clog2(NUM_CS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RAW-1:0]    reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              dec_req,
   input  logic [ADDR_W-1:0] dec_addr,
   output logic              dec_vld,
   output logic [NUM_CS-1:0] dec_sel,
   output logic [ADDR_W-1:0] dec_off,
   input  logic              acc_req,
   input  logic [CSW-1:0]    acc_cs,
   input  logic [ADDR_W-1:0] acc_off,
   output logic              acc_vld,
   output logic [ADDR_W-1:0] acc_off_q
);
   // elaboration-time parameter checks
   if (NUM_CS < 1) begin : g_bad_cs
      $error("NUM_CS must be at least 1");
   end
   if (ADDR_W - UNIT_SH < UNIT_W) begin : g_bad_aw
      $error("ADDR_W must leave at least 8 unit bits above UNIT_SH");
   end
   if (BASE_U + CS0_U + (NUM_CS - 1) * CSN_U > 255) begin : g_bad_dflt
      $error("default windows exceed the 8-bit unit field");
   end

   logic [31:0]          seg_q [NUM_CS];
   logic [NUM_CS*16-1:0] seg_hi;
   logic [NUM_CS*32-1:0] seg_flat;
   logic [ST_W-1:0]      stat_q, stat_set, stat_clr;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_flat
      assign seg_hi[i*16 +: 16]   = seg_q[i][31:16];
      assign seg_flat[i*32 +: 32] = seg_q[i];
   end

   // ---------------- register write path ----------------
   logic [CSW-1:0] wcs;
   logic [31:0]    cur;
   logic           wsel, wstat, differs;
   logic [15:0]    store_hi;
   logic           f_rej, f_mis, f_ovl, wdo;

   assign wcs = CSW'(reg_addr);

   always_comb begin
      wsel = 1'b0;
      cur  = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (reg_addr == RAW'(i)) begin
            wsel = reg_wr;
            cur  = seg_q[i];
         end
      end
   end

   assign wstat   = reg_wr && (reg_addr == RAW'(NUM_CS));
   assign differs = (reg_wdata != cur);
   assign wdo     = wsel && differs;

   seg_wr_check #(
      .NUM_CS(NUM_CS), .BASE_U(BASE_U), .WIN_U(WIN_U), .NPOT(NPOT)
   ) u_wchk (
      .cs(wcs), .wfield(reg_wdata[31:16]), .seg_hi(seg_hi),
      .store_hi(store_hi), .reject(f_rej), .misalign(f_mis), .overlap(f_ovl)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_seg
      localparam int S = (i == 0) ? BASE_U : BASE_U + CS0_U + (i - 1) * CSN_U;
      localparam int E = S + ((i == 0) ? CS0_U : CSN_U);
      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_q[i] <= {8'(E), 8'(S), 16'h0};
         else if (wdo && (wcs == CSW'(i)) && !f_rej)
            seg_q[i] <= {store_hi, 16'h0};
      end
   end

   // ---------------- flash access folding ----------------
   logic [UNIT_W-1:0] acc_sz;
   logic [ADDR_W-1:0] acc_fold;
   logic              acc_over;

   always_comb begin
      acc_sz = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (acc_cs == CSW'(i)) acc_sz = seg_len(seg_q[i][31:24], seg_q[i][23:16]);
   end

   seg_off_wrap #(.ADDR_W(ADDR_W), .UNIT_SH(UNIT_SH), .NPOT(NPOT)) u_wrap (
      .off(acc_off), .size_u(acc_sz), .off_o(acc_fold), .over(acc_over)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_vld   <= 1'b0;
         acc_off_q <= '0;
      end else begin
         acc_vld   <= acc_req;
         acc_off_q <= acc_req ? acc_fold : '0;
      end
   end

   // ---------------- system decode ----------------
   logic [NUM_CS-1:0] sel_c;
   logic [ADDR_W-1:0] off_c;

   seg_addr_dec #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .UNIT_SH(UNIT_SH)) u_dec (
      .addr(dec_addr), .seg_hi(seg_hi), .sel(sel_c), .off(off_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_vld <= 1'b0;
         dec_sel <= '0;
         dec_off <= '0;
      end else begin
         dec_vld <= dec_req;
         dec_sel <= dec_req ? sel_c : '0;
         dec_off <= dec_req ? off_c : '0;
      end
   end

   // ---------------- sticky status ----------------
   always_comb begin
      stat_set          = '0;
      stat_set[ST_OVL]  = wdo && !f_rej && f_ovl;
      stat_set[ST_MIS]  = wdo && !f_rej && f_mis;
      stat_set[ST_REJ]  = wdo && f_rej;
      stat_set[ST_WRAP] = acc_req && acc_over;
      stat_clr          = wstat ? reg_wdata[ST_W-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (reg_addr == RAW'(i)) reg_rdata = seg_q[i];
      if (reg_addr == RAW'(NUM_CS)) reg_rdata = 32'(stat_q);
   end
endmodule

// File: rtl/seg_window_chk.sv
module seg_window_chk
   import seg_pkg::*;
#(
   parameter int NUM_CS  = 5,
   parameter int ADDR_W  = 32,
   parameter int UNIT_SH = 23,
   parameter int BASE_U  = 'h40,
   localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int RAW    = $clog2(NUM_CS + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [RAW-1:0]       reg_addr,
   input logic [31:0]          reg_wdata,
   input logic                 dec_req,
   input logic                 dec_vld,
   input logic [NUM_CS-1:0]    dec_sel,
   input logic                 acc_req,
   input logic [CSW-1:0]       acc_cs,
   input logic [ADDR_W-1:0]    acc_off_q,
   input logic [NUM_CS*32-1:0] seg_flat,
   input logic [ST_W-1:0]      stat_q
);
   logic [15:0]       low_or;
   logic [UNIT_W-1:0] sz;
   logic              same_wr;
   logic [ST_W-1:0]   keep;

   always_comb begin
      low_or  = '0;
      sz      = '0;
      same_wr = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         low_or = low_or | seg_flat[i*32 +: 16];
         if (acc_cs == CSW'(i))
            sz = seg_len(seg_flat[i*32+24 +: 8], seg_flat[i*32+16 +: 8]);
         if (reg_wr && reg_addr == RAW'(i) && reg_wdata == seg_flat[i*32 +: 32])
            same_wr = 1'b1;
      end
      keep = stat_q & ~((reg_wr && reg_addr == RAW'(NUM_CS)) ? reg_wdata[ST_W-1:0] : '0);
   end

   assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      low_or == '0);

   assert_cs0_start_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seg_flat[23:16] == 8'(BASE_U));

   assert_same_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      same_wr |=> ($stable(seg_flat) && stat_q[2:0] == $past(stat_q[2:0])));

   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_sel));

   assert_dec_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_req |=> dec_vld);

   assert_fold_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && sz != '0) |=> (acc_off_q[ADDR_W-1:UNIT_SH] < (ADDR_W-UNIT_SH)'($past(sz))));

   assert_fold_empty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && sz == '0) |=> (acc_off_q == '0));

   assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(keep)) == $past(keep)));
endmodule

bind seg_window_dec seg_window_chk #(
   .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .UNIT_SH(UNIT_SH), .BASE_U(BASE_U)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .dec_req(dec_req), .dec_vld(dec_vld),
   .dec_sel(dec_sel), .acc_req(acc_req), .acc_cs(acc_cs),
   .acc_off_q(acc_off_q), .seg_flat(seg_flat), .stat_q(stat_q)
);

// File: tb/sim_seg_window_dec.sv
module sim_seg_window_dec;
   localparam int NUM_CS = 5;
   localparam int ADDR_W = 32;
   localparam int CSW    = 3;
   localparam int RAW    = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [RAW-1:0]    reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              dec_req = 1'b0;
   logic [ADDR_W-1:0] dec_addr = '0;
   logic              dec_vld;
   logic [NUM_CS-1:0] dec_sel;
   logic [ADDR_W-1:0] dec_off;
   logic              acc_req = 1'b0;
   logic [CSW-1:0]    acc_cs = '0;
   logic [ADDR_W-1:0] acc_off = '0;
   logic              acc_vld;
   logic [ADDR_W-1:0] acc_off_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [NUM_CS+ADDR_W-1:0] dq[$];
   string                    dtag[$];
   logic [ADDR_W-1:0]        aq[$];
   string                    atag[$];

   always #5 clk = ~clk;

   seg_window_dec u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dec_req(dec_req),
      .dec_addr(dec_addr), .dec_vld(dec_vld), .dec_sel(dec_sel),
      .dec_off(dec_off), .acc_req(acc_req), .acc_cs(acc_cs),
      .acc_off(acc_off), .acc_vld(acc_vld), .acc_off_q(acc_off_q)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = RAW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = RAW'(a);
      #1;
      check(tag, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic dec(input logic [31:0] a, input logic [NUM_CS-1:0] s,
                      input logic [31:0] o, input string tag);
      @(negedge clk);
      dec_req = 1'b1; dec_addr = a;
      dq.push_back({s, o}); dtag.push_back(tag);
      @(negedge clk);
      dec_req = 1'b0;
   endtask

   task automatic acc(input int cs, input logic [31:0] o, input logic [31:0] exp,
                      input string tag);
      @(negedge clk);
      acc_req = 1'b1; acc_cs = CSW'(cs); acc_off = o;
      aq.push_back(exp); atag.push_back(tag);
      @(negedge clk);
      acc_req = 1'b0;
   endtask

   // monitor: compare results against the scoreboard queues
   always @(negedge clk) begin
      if (dec_vld) begin
         if (dq.size() == 0) check("R8 unexpected decode", 64'(dec_sel), 64'hx);
         else check(dtag.pop_front(), 64'({dec_sel, dec_off}), 64'(dq.pop_front()));
      end
      if (acc_vld) begin
         if (aq.size() == 0) check("R9 unexpected access", 64'(acc_off_q), 64'hx);
         else check(atag.pop_front(), 64'(acc_off_q), 64'(aq.pop_front()));
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset defaults
      rd(0, 32'h4840_0000, "R2 cs0 default");
      rd(1, 32'h4C48_0000, "R2 cs1 default");
      rd(4, 32'h5854_0000, "R2 cs4 default");
      rd(5, 32'h0, "R2 status clear");
      rd(7, 32'h0, "R1 unused index reads zero");

      // decode
      dec(32'h2000_0010, 5'b00001, 32'h10, "R8 cs0 hit");
      dec(32'h2400_0004, 5'b00010, 32'h4, "R8 end is exclusive");
      dec(32'h2B00_0000, 5'b10000, 32'h0100_0000, "R8 cs4 hit");
      dec(32'h2C00_0000, 5'b00000, 32'h0, "R8 miss above");
      dec(32'h1FFF_FFFF, 5'b00000, 32'h0, "R8 miss below");

      // cs0 start lock, overlap, clearing
      wr(0, 32'h5030_1234);
      rd(0, 32'h5040_0000, "R3 start forced to base");
      rd(5, 32'h1, "R6 overlap flagged");
      wr(5, 32'h0);
      rd(5, 32'h1, "R10 zero write keeps flag");
      wr(5, 32'h1);
      rd(5, 32'h0, "R10 w1c clears");
      wr(0, 32'h4840_0000);
      rd(5, 32'h0, "R6 touching windows do not overlap");

      // out-of-window rejects
      wr(1, 32'h4038_0000);
      rd(1, 32'h4C48_0000, "R4 low end rejected keeps value");
      rd(5, 32'h4, "R4 reject flag");
      wr(5, 32'hF);
      wr(2, 32'h7061_0000);
      rd(2, 32'h504C_0000, "R4 high start rejected");
      rd(5, 32'h4, "R4 reject flag high");
      wr(5, 32'hF);
      wr(2, 32'h6460_0000);
      rd(2, 32'h6460_0000, "R4 start at limit accepted");
      rd(5, 32'h0, "R4 limit start no flag");
      dec(32'h3000_0008, 5'b00100, 32'h8, "R8 moved window");
      wr(2, 32'h504C_0000);

      // misalignment with non-power-of-two size
      wr(3, 32'h5350_0000);
      rd(3, 32'h5350_0000, "R5 misaligned stored");
      rd(5, 32'h2, "R5 misalign flag");
      dec(32'h2900_0000, 5'b01000, 32'h0100_0000, "R8 size-3 window");
      dec(32'h2980_0000, 5'b00000, 32'h0, "R8 beyond size-3 window");

      // identical write
      wr(5, 32'hF);
      wr(3, 32'h5350_0000);
      rd(5, 32'h0, "R7 identical write no flag");
      rd(3, 32'h5350_0000, "R7 identical write no change");

      // offset folding
      acc(3, 32'h0200_0000, 32'h0080_0000, "R9 npot fold");
      rd(5, 32'h8, "R9 wrap flag");
      wr(5, 32'hF);
      acc(3, 32'h0123_4567, 32'h0123_4567, "R9 in range unchanged");
      rd(5, 32'h0, "R9 in range no flag");
      acc(3, 32'hFFFF_FFFF, 32'h00FF_FFFF, "R9 npot fold max");
      acc(0, 32'h0410_0000, 32'h0010_0000, "R9 pow2 fold");
      acc(0, 32'h03FF_FFFF, 32'h03FF_FFFF, "R9 pow2 last byte");
      acc(1, 32'h0BC0_0001, 32'h01C0_0001, "R9 pow2 size4 fold");

      // empty window
      wr(5, 32'hF);
      wr(2, 32'h4A4A_0000);
      rd(5, 32'h0, "R6 empty window no overlap");
      dec(32'h2500_0000, 5'b00010, 32'h0100_0000, "R8 empty window never hits");
      acc(2, 32'h0000_0100, 32'h0, "R9 empty size folds to zero");
      rd(5, 32'h8, "R9 empty size flag");

      // overlapping windows and priority
      wr(5, 32'hF);
      wr(2, 32'h504A_0000);
      rd(5, 32'h3, "R6 overlap and R5 misalign");
      dec(32'h2500_0000, 5'b00010, 32'h0100_0000, "R8 lowest index wins");
      dec(32'h2600_0000, 5'b00100, 32'h0100_0000, "R8 second window past first");

      // partial clear and set-wins
      wr(5, 32'h2);
      rd(5, 32'h1, "R10 partial w1c");
      @(negedge clk);
      acc_req = 1'b1; acc_cs = 3'd0; acc_off = 32'h0400_0000;
      aq.push_back(32'h0); atag.push_back("R9 fold at size");
      reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h8;
      @(negedge clk);
      acc_req = 1'b0; reg_wr = 1'b0;
      rd(5, 32'h9, "R10 set wins over clear");

      repeat (4) @(negedge clk);
      check("R8 decode queue drained", 64'(dq.size()), 64'd0);
      check("R9 access queue drained", 64'(aq.size()), 64'd0);
      done = 1'b1;
      finish_run();
   end
endmodule